// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the integer datapath of a small RISC core. In one cycle it combines two byte operands under a five-bit operation code. It produces the byte result and a strobe that says whether that result should be written back. It also presents the next value of six status flags: half carry, sign, overflow, negative, zero and carry.

A per-flag mask shows which flags the operation touches. Each operation class has its own fixed subset of flags. The flags are held in a register inside the block. That register supplies the carry-in for carry-chained operations and the old zero flag for chained compares. It loads the new values whenever the execute strobe is high.

The block covers these operations: add and subtract with and without carry, bitwise logic, one's and two's complement, increment and decrement, shifts and rotates through carry, nibble exchange, and compare (flags only).

Top module: `alu8_core`

## Requirements
- R1: Operation codes are ADD 0, ADDC 1, SUB 2, SUBC 3, AND 4, OR 5, XOR 6, NOT 7, NEG 8, INC 9, DEC 10, SHL 11, SHR 12, RLC 13, RRC 14, SAR 15, NSWAP 16, CMP 17, CMPC 18. In the flag vectors, carry is bit 0, zero bit 1, negative bit 2, overflow bit 3, sign bit 4 and half carry bit 5.
- R2: ADD gives a+b and ADDC gives a+b+carry, both modulo 256. Carry is the carry out of bit 7, half carry the carry out of bit 3, and overflow the two's-complement overflow. All six flags are updated.
- R3: SUB gives a-b, SUBC gives a-b-carry and NEG gives 0-a, all modulo 256. Carry is the borrow out of bit 7, half carry the borrow out of bit 3, and overflow the signed overflow. All six flags are updated.
- R4: For SUBC and CMPC the zero flag becomes 1 only if the byte difference is zero and the zero flag was already 1. It is never newly set.
- R5: CMP and CMPC produce the same flags as SUB and SUBC, and hold the write strobe low.
- R6: AND, OR and XOR give the bitwise result and clear overflow. Carry and half carry are kept.
- R7: INC and DEC add or subtract one. Overflow is set exactly when the result is 0x80 for INC or 0x7F for DEC. Carry and half carry are kept.
- R8: NOT gives 0xFF minus a, sets carry and clears overflow. Half carry is kept.
- R9: SHL and SHR shift in a zero. RLC and RRC rotate through the carry flag. SAR keeps bit 7. The bit shifted out becomes carry, overflow becomes negative XOR carry, and half carry is kept.
- R10: NSWAP exchanges the upper and lower nibbles and changes no flag. Codes 19 to 31 hold the write strobe low and change no flag.
- R11: Negative is result bit 7 and zero means a zero result. Whenever sign is updated it equals negative XOR overflow.
- R12: Reset clears the flag register. With the execute strobe high the register loads the next-flag vector, whose unmasked bits equal the current flags. With the strobe low the register holds. The mask is 1 exactly on the flags the operation updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_en | input | 1 | Commit the next-flag vector this cycle |
| opc | input | 5 | Operation code |
| src_a | input | 8 | First operand |
| src_b | input | 8 | Second operand |
| result | output | 8 | Byte result |
| res_we | output | 1 | Result should be written back |
| flg_nxt | output | 6 | Flags after this operation (unmasked bits equal current) |
| flg_mask | output | 6 | Flags this operation updates |
| flg_q | output | 6 | Registered status flags |

## Verification
The assertions assume that exec_en and opc are driven to known values from the first clock after reset. They also assume that a carry- or zero-chained operation reads the flag register as it stands in that cycle. The stimulus meets both conditions: it changes inputs only on the falling edge, holds them stable across the rising edge, and never releases reset with undefined inputs.

The sweep lets the flag register evolve freely through long operation runs, with the execute strobe gated off on a regular pattern. Chained carry, sticky zero and the hold behaviour are therefore exercised from many prior states.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADDC  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBC  = 5'd3,
        OP_AND   = 5'd4,
        OP_OR    = 5'd5,
        OP_XOR   = 5'd6,
        OP_NOT   = 5'd7,
        OP_NEG   = 5'd8,
        OP_INC   = 5'd9,
        OP_DEC   = 5'd10,
        OP_SHL   = 5'd11,
        OP_SHR   = 5'd12,
        OP_RLC   = 5'd13,
        OP_RRC   = 5'd14,
        OP_SAR   = 5'd15,
        OP_NSWAP = 5'd16,
        OP_CMP   = 5'd17,
        OP_CMPC  = 5'd18
    } alu_op_e;

    // Member order fixes the bit positions: c is bit 0, h is bit 5.
    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

    function automatic logic op_is_arith(alu_op_e op);
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_NEG,
            OP_INC, OP_DEC, OP_CMP, OP_CMPC: op_is_arith = 1'b1;
            default:                         op_is_arith = 1'b0;
        endcase
    endfunction

    function automatic logic op_is_sub(alu_op_e op);
        case (op)
            OP_SUB, OP_SUBC, OP_NEG, OP_DEC, OP_CMP, OP_CMPC: op_is_sub = 1'b1;
            default:                                          op_is_sub = 1'b0;
        endcase
    endfunction

    function automatic logic op_uses_carry(alu_op_e op);
        op_uses_carry = (op == OP_ADDC) || (op == OP_SUBC) || (op == OP_CMPC);
    endfunction

    function automatic logic op_is_shift(alu_op_e op);
        op_is_shift = (op == OP_SHL) || (op == OP_SHR) || (op == OP_RLC) ||
                      (op == OP_RRC) || (op == OP_SAR);
    endfunction

    function automatic logic op_is_logic(alu_op_e op);
        op_is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic op_writes(logic [4:0] code);
        op_writes = (code <= 5'd16);
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          hcar,
    output logic          ovf
);
    localparam int NB  = DW / 2;
    localparam int MSB = DW - 1;

    logic [DW-1:0] addend;
    logic          cin_eff;
    logic [DW:0]   full;
    logic [NB:0]   low;

    // Subtraction as a + ~b + ~borrow_in; a borrow is the absence of a carry.
    always_comb begin
        addend  = sub ? ~b : b;
        cin_eff = sub ? ~cin : cin;
        full    = {1'b0, a} + {1'b0, addend} + {{DW{1'b0}}, cin_eff};
        low     = {1'b0, a[NB-1:0]} + {1'b0, addend[NB-1:0]} + {{NB{1'b0}}, cin_eff};
        sum     = full[DW-1:0];
        cout    = sub ? ~full[DW] : full[DW];
        hcar    = sub ? ~low[NB] : low[NB];
        ovf     = (a[MSB] == addend[MSB]) && (full[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout
);
    localparam int NB  = DW / 2;
    localparam int MSB = DW - 1;

    always_comb begin
        res  = a;
        cout = cin;
        case (op)
            OP_AND:   res = a & b;
            OP_OR:    res = a | b;
            OP_XOR:   res = a ^ b;
            OP_NOT: begin
                res  = ~a;
                cout = 1'b1;
            end
            OP_SHL: begin
                res  = {a[MSB-1:0], 1'b0};
                cout = a[MSB];
            end
            OP_SHR: begin
                res  = {1'b0, a[MSB:1]};
                cout = a[0];
            end
            OP_RLC: begin
                res  = {a[MSB-1:0], cin};
                cout = a[MSB];
            end
            OP_RRC: begin
                res  = {cin, a[MSB:1]};
                cout = a[0];
            end
            OP_SAR: begin
                res  = {a[MSB], a[MSB:1]};
                cout = a[0];
            end
            OP_NSWAP: res = {a[NB-1:0], a[MSB:NB]};
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_flagmix.sv
module alu8_flagmix
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] res,
    input  logic          ar_c,
    input  logic          ar_h,
    input  logic          ar_v,
    input  logic          bo_c,
    input  flags_t        cur,
    output flags_t        nxt,
    output flags_t        mask
);
    localparam int MSB = DW - 1;

    logic zr;
    logic ng;

    always_comb begin
        zr   = (res == '0);
        ng   = res[MSB];
        nxt  = cur;
        mask = '0;
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_NEG, OP_CMP, OP_CMPC: begin
                nxt.h = ar_h;
                nxt.c = ar_c;
                nxt.v = ar_v;
                nxt.n = ng;
                nxt.z = (op == OP_SUBC || op == OP_CMPC) ? (zr & cur.z) : zr;
                nxt.s = ng ^ ar_v;
                mask  = '1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                nxt.v = 1'b0;
                nxt.n = ng;
                nxt.z = zr;
                nxt.s = ng;
                mask  = '{h: 1'b0, s: 1'b1, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b0};
            end
            OP_INC, OP_DEC: begin
                nxt.v = ar_v;
                nxt.n = ng;
                nxt.z = zr;
                nxt.s = ng ^ ar_v;
                mask  = '{h: 1'b0, s: 1'b1, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b0};
            end
            OP_NOT: begin
                nxt.c = 1'b1;
                nxt.v = 1'b0;
                nxt.n = ng;
                nxt.z = zr;
                nxt.s = ng;
                mask  = '{h: 1'b0, s: 1'b1, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
            end
            OP_SHL, OP_SHR, OP_RLC, OP_RRC, OP_SAR: begin
                nxt.c = bo_c;
                nxt.v = ng ^ bo_c;
                nxt.n = ng;
                nxt.z = zr;
                nxt.s = bo_c;
                mask  = '{h: 1'b0, s: 1'b1, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  logic [4:0]        opc,
    input  logic [DW-1:0]     src_a,
    input  logic [DW-1:0]     src_b,
    output logic [DW-1:0]     result,
    output logic              res_we,
    output logic [FLAG_W-1:0] flg_nxt,
    output logic [FLAG_W-1:0] flg_mask,
    output logic [FLAG_W-1:0] flg_q
);
    alu_op_e       op;
    flags_t        flg_d, flg_q_r;
    flags_t        nxt_w, mask_w;
    logic [DW-1:0] ar_a, ar_b, ar_sum, bo_res;
    logic          ar_cin, ar_c, ar_h, ar_v, bo_c;

    assign op = alu_op_e'(opc);

    always_comb begin
        ar_a   = (op == OP_NEG) ? '0 : src_a;
        ar_b   = (op == OP_NEG) ? src_a :
                 (op == OP_INC || op == OP_DEC) ? DW'(1) : src_b;
        ar_cin = op_uses_carry(op) ? flg_q_r.c : 1'b0;
    end

    alu8_arith #(.DW(DW)) u_arith (
        .a    (ar_a),
        .b    (ar_b),
        .cin  (ar_cin),
        .sub  (op_is_sub(op)),
        .sum  (ar_sum),
        .cout (ar_c),
        .hcar (ar_h),
        .ovf  (ar_v)
    );

    alu8_bitops #(.DW(DW)) u_bitops (
        .op   (op),
        .a    (src_a),
        .b    (src_b),
        .cin  (flg_q_r.c),
        .res  (bo_res),
        .cout (bo_c)
    );

    always_comb begin
        result = op_is_arith(op) ? ar_sum : bo_res;
        res_we = op_writes(opc) && (op != OP_CMP) && (op != OP_CMPC);
    end

    alu8_flagmix #(.DW(DW)) u_flagmix (
        .op   (op),
        .res  (result),
        .ar_c (ar_c),
        .ar_h (ar_h),
        .ar_v (ar_v),
        .bo_c (bo_c),
        .cur  (flg_q_r),
        .nxt  (nxt_w),
        .mask (mask_w)
    );

    assign flg_nxt  = nxt_w;
    assign flg_mask = mask_w;
    assign flg_q    = flg_q_r;

    always_comb begin
        flg_d = exec_en ? nxt_w : flg_q_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q_r <= '0;
        else        flg_q_r <= flg_d;
    end

    // R12: an idle cycle leaves the flag register untouched.
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> $stable(flg_q_r));

    // R5: compares never request a write-back.
    p_cmp_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CMP || op == OP_CMPC) |-> !res_we);

    // R4: chained subtract cannot raise a cleared zero flag.
    p_zsticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && (op == OP_SUBC || op == OP_CMPC) && !flg_q_r.z) |=> !flg_q_r.z);

    // R10: nibble exchange leaves all flags as they were.
    p_swap_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op == OP_NSWAP) |=> $stable(flg_q_r));

    // R6: logic operations leave overflow clear.
    p_logic_vclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_is_logic(op)) |=> !flg_q_r.v);

    // R8: complement leaves carry set.
    p_not_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op == OP_NOT) |=> flg_q_r.c);

    // R7: increment and decrement keep carry.
    p_incdec_keepc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && (op == OP_INC || op == OP_DEC)) |=> (flg_q_r.c == $past(flg_q_r.c)));

    // R11: after a shift the stored sign agrees with negative and overflow.
    p_sign_rule_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_is_shift(op)) |=> (flg_q_r.s == (flg_q_r.n ^ flg_q_r.v)));

endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       exec_en;
    logic [4:0] opc;
    logic [7:0] src_a, src_b, result;
    logic       res_we;
    logic [5:0] flg_nxt, flg_mask, flg_q;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;
    logic [5:0] mf;

    always #4 clk = ~clk;

    alu8_core u0 (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opc(opc),
        .src_a(src_a), .src_b(src_b), .result(result), .res_we(res_we),
        .flg_nxt(flg_nxt), .flg_mask(flg_mask), .flg_q(flg_q)
    );

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s op=%0d a=%0h b=%0h act=%0h exp=%0h",
                     tag, what, opc, src_a, src_b, act, exp);
        end
    endtask

    function automatic string rq(int op);
        case (op)
            0, 1:          return "R2";
            2, 8:          return "R3";
            3:             return "R3/R4";
            17:            return "R5";
            18:            return "R5/R4";
            4, 5, 6:       return "R6";
            9, 10:         return "R7";
            7:             return "R8";
            11, 12, 13, 14, 15: return "R9";
            default:       return "R10";
        endcase
    endfunction

    function automatic int sg(int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    // Flag bits: C0 Z1 N2 V3 S4 H5.
    task automatic ref_model(input int op, input int a, input int b, input logic [5:0] fq,
                             output int r, output logic [5:0] nf,
                             output logic [5:0] m, output logic we);
        int  ci, t, sv;
        logic nc, nh, nv, nz, nn;
        logic [5:0] cand;
        logic cold, zold;
        cold = fq[0];
        zold = fq[1];
        r = a; nc = cold; nh = fq[5]; nv = fq[3]; we = 1'b1; m = 6'b000000;
        nz = 1'b0;
        case (op)
            0, 1: begin
                ci = (op == 1) ? int'(cold) : 0;
                t  = a + b + ci;
                r  = t % 256;
                nc = (t > 255);
                nh = ((a % 16) + (b % 16) + ci) > 15;
                sv = sg(a) + sg(b) + ci;
                nv = (sv > 127) || (sv < -128);
                m  = 6'b111111;
            end
            2, 3, 17, 18: begin
                ci = (op == 3 || op == 18) ? int'(cold) : 0;
                t  = a - b - ci;
                r  = (t + 512) % 256;
                nc = (t < 0);
                nh = ((a % 16) - (b % 16) - ci) < 0;
                sv = sg(a) - sg(b) - ci;
                nv = (sv > 127) || (sv < -128);
                m  = 6'b111111;
                we = (op < 17);
            end
            8: begin
                r  = (256 - a) % 256;
                nc = (a != 0);
                nh = (a % 16) != 0;
                nv = (a == 128);
                m  = 6'b111111;
            end
            4: begin r = a & b; nv = 1'b0; m = 6'b011110; end
            5: begin r = a | b; nv = 1'b0; m = 6'b011110; end
            6: begin r = a ^ b; nv = 1'b0; m = 6'b011110; end
            7: begin r = 255 - a; nc = 1'b1; nv = 1'b0; m = 6'b011111; end
            9:  begin r = (a + 1) % 256;   nv = (r == 128); m = 6'b011110; end
            10: begin r = (a + 255) % 256; nv = (r == 127); m = 6'b011110; end
            11: begin r = (a * 2) % 256;               nc = (a >= 128); m = 6'b011111; end
            12: begin r = a / 2;                       nc = (a % 2) == 1; m = 6'b011111; end
            13: begin r = (a * 2) % 256 + int'(cold);  nc = (a >= 128); m = 6'b011111; end
            14: begin r = a / 2 + 128 * int'(cold);    nc = (a % 2) == 1; m = 6'b011111; end
            15: begin r = a / 2 + (a & 128);           nc = (a % 2) == 1; m = 6'b011111; end
            16: begin r = (a % 16) * 16 + a / 16; end
            default: we = 1'b0;
        endcase
        nn = (r >= 128);
        nz = (r == 0);
        if (op == 3 || op == 18) nz = nz && zold;
        if (op >= 11 && op <= 15) nv = nn ^ nc;
        cand = {nh, nn ^ nv, nv, nn, nz, nc};
        nf = (fq & ~m) | (cand & m);
    endtask

    task automatic run(int op, int a, int b, bit en);
        int r;
        logic [5:0] nf, m;
        logic we;
        @(negedge clk);
        opc = 5'(op); src_a = 8'(a); src_b = 8'(b); exec_en = en;
        #1;
        ref_model(op, a, b, mf, r, nf, m, we);
        chk(rq(op), "write_strobe", int'(res_we), int'(we));
        if (we) chk(rq(op), "result", int'(result), r);
        chk(rq(op), "next_flags", int'(flg_nxt), int'(nf));
        chk("R1/R12", "flag_mask", int'(flg_mask), int'(m));
        if (m[4]) chk("R11", "sign_rule", int'(flg_nxt[4]), int'(flg_nxt[3] ^ flg_nxt[2]));
        @(posedge clk);
        #1;
        if (en) mf = nf;
        chk("R12", "flag_register", int'(flg_q), int'(mf));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R12 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; exec_en = 1'b0; opc = '0; src_a = '0; src_b = '0;
        mf = 6'b000000;
        repeat (3) @(posedge clk);
        #1;
        chk("R12", "reset_flags", int'(flg_q), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: sticky zero from both starting states
        run(3, 5, 5, 1'b1);      // Z was 0: stays 0
        run(0, 0, 0, 1'b1);      // sets Z, clears C
        run(18, 7, 7, 1'b1);     // Z was 1, difference 0: stays 1
        run(3, 9, 8, 1'b1);      // difference nonzero: Z cleared
        // R12: idle cycle with a flag-changing operation presented
        run(7, 0, 0, 1'b0);
        // R7 boundaries
        run(9, 127, 0, 1'b1);
        run(10, 128, 0, 1'b1);
        // R10: undefined codes
        run(31, 200, 3, 1'b1);
        run(19, 0, 0, 1'b1);

        for (int op = 0; op <= 20; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int bi = 0; bi < 16; bi++) begin
                    int b;
                    b = (bi == 0) ? a : (bi * 17 + (a & 3)) % 256;
                    run(op, a, b, ((a + bi) % 7) != 3);
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule